// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the one atomic reservation of a 32-bit core. The core drives two request lanes into it each cycle. The load lane carries a main opcode and a finished effective address. The store lane carries the same two fields for plain stores and conditional stores. Base-plus-offset address arithmetic is done before the block.

A load-reserve records its address and marks the reservation live. A conditional store is judged in the same cycle against the held reservation. The block returns a pass/fail flag that the core writes into its status flag bit. It also returns a write enable that lets the conditional store reach memory only when it passes. A plain store to the reserved word, or any conditional store, ends the reservation. Opcodes are the 6-bit main opcode taken from instruction bits [31:26].

Top module: `llsc_monitor`

## Requirements
- R1: While rst_n is low at a rising clock edge, the edge clears resv_valid to 0 and resv_addr to 0.
- R2: A load-lane request with opcode 0x1B (load-reserve) sets resv_valid to 1 and stores ld_addr into resv_addr at the next rising edge.
- R3: A store-lane request with opcode 0x33 (conditional store) drives sc_flag high in the same cycle exactly when resv_valid is 1 and the addresses match. Otherwise sc_flag is low, and it is low in any cycle with no conditional store.
- R4: sc_wr_en equals sc_flag in every cycle, so the conditional word write reaches memory only when it passes.
- R5: After any conditional store, whether it passes or fails, resv_valid is 0 at the next edge. This holds unless a load-reserve arrives in the same cycle.
- R6: A store-lane request with a plain-store opcode (0x34, 0x35, 0x36 or 0x37) clears resv_valid when its word matches resv_addr. A plain store to any other word leaves resv_valid and resv_addr unchanged.
- R7: Both address compares ignore address bits [1:0]. A byte address anywhere inside the reserved word counts as a match.
- R8: When a load-reserve and a store-lane request that would clear the reservation occur in the same cycle, the load-reserve wins. The next state is valid with the new address. A conditional store in that cycle is still judged against the old reservation.
- R9: Requests with the lane's valid bit low have no effect on either output or on the reservation. The same holds for opcodes not assigned to a lane, including 0x33 on the load lane and 0x1B on the store lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_req | input | 1 | Load lane request valid |
| ld_opc | input | 6 | Load lane main opcode |
| ld_addr | input | 32 | Load lane effective address |
| st_req | input | 1 | Store lane request valid |
| st_opc | input | 6 | Store lane main opcode |
| st_addr | input | 32 | Store lane effective address |
| sc_flag | output | 1 | Conditional store outcome for the status flag |
| sc_wr_en | output | 1 | Gate for the conditional store memory write |
| resv_valid | output | 1 | Reservation live |
| resv_addr | output | 32 | Recorded reservation address |

## Verification
A wrong reservation state shows up on resv_valid and resv_addr one edge after the request that caused it. It also shows up on sc_flag and sc_wr_en during the next conditional store, in that same cycle. A reservation that is not killed by a plain store would make a later conditional store pass when it should fail. A stray write enable shows in the bench memory model as a word that should have stayed untouched. Lane priority is exercised by combining a load-reserve with each kind of store in one cycle.

// File: rtl/llsc_pkg.sv
// Shared constants and types for the reservation monitor.
// Assumes 6-bit main opcodes taken from instruction bits [31:26].
package llsc_pkg;
    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_LOAD_RESV = 6'h1B;
    localparam logic [OPC_W-1:0] OPC_COND_ST   = 6'h33;
    localparam logic [OPC_W-1:0] OPC_ST_DBL    = 6'h34;
    localparam logic [OPC_W-1:0] OPC_ST_WORD   = 6'h35;
    localparam logic [OPC_W-1:0] OPC_ST_BYTE   = 6'h36;
    localparam logic [OPC_W-1:0] OPC_ST_HALF   = 6'h37;

    typedef enum logic [1:0] {
        OPK_NONE     = 2'd0,
        OPK_LOADRES  = 2'd1,
        OPK_PLAIN_ST = 2'd2,
        OPK_COND_ST  = 2'd3
    } op_kind_e;
endpackage

// File: rtl/mon_opclass.sv
// Classifies one request lane's opcode into an operation kind.
// STORE_LANE selects which opcodes the lane accepts; others map to none.
module mon_opclass
    import llsc_pkg::*;
#(
    parameter bit STORE_LANE = 1'b0
) (
    input  logic             req,
    input  logic [OPC_W-1:0] opc,
    output op_kind_e         kind
);
    generate
        if (STORE_LANE) begin : g_store
            // Store lane: plain stores and the conditional store.
            always_comb begin
                kind = OPK_NONE;
                if (req) begin
                    unique case (opc)
                        OPC_COND_ST:                              kind = OPK_COND_ST;
                        OPC_ST_DBL, OPC_ST_WORD,
                        OPC_ST_BYTE, OPC_ST_HALF:                 kind = OPK_PLAIN_ST;
                        default:                                  kind = OPK_NONE;
                    endcase
                end
            end
        end else begin : g_load
            // Load lane: only the load-reserve opcode matters.
            always_comb begin
                kind = OPK_NONE;
                if (req && opc == OPC_LOAD_RESV) kind = OPK_LOADRES;
            end
        end
    endgenerate
endmodule

// File: rtl/mon_word_match.sv
// Compares two addresses at word granularity.
// Assumes the low IGN_LSB bits select a byte within the word.
module mon_word_match #(
    parameter int ADDR_W  = 32,
    parameter int IGN_LSB = 2
) (
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    output logic              hit
);
    localparam int TAG_W = ADDR_W - IGN_LSB;

    logic [TAG_W-1:0] tag_a, tag_b;

    // Drop the byte-select bits and compare what remains.
    always_comb begin
        tag_a = a[ADDR_W-1:IGN_LSB];
        tag_b = b[ADDR_W-1:IGN_LSB];
        hit   = (tag_a == tag_b);
    end
endmodule

// File: rtl/mon_resv_state.sv
// Holds the reservation bit and address.
// Set has priority over clear; reset is synchronous, active low.
module mon_resv_state #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr_en,
    output logic              valid,
    output logic [ADDR_W-1:0] addr
);
    // Reservation flag: fresh reservation beats any kill in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid <= 1'b0;
        else if (set_en) valid <= 1'b1;
        else if (clr_en) valid <= 1'b0;
    end

    // Recorded address: loaded only by a load-reserve.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr <= '0;
        else if (set_en) addr <= set_addr;
    end
endmodule

// File: rtl/llsc_monitor.sv
// Single-reservation monitor for load-reserve / conditional-store pairs.
// Assumes finished effective addresses and one request per lane per cycle.
// Conditional stores are judged combinationally against the held state.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IGN_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req,
    input  logic [5:0]        ld_opc,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_req,
    input  logic [5:0]        st_opc,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              sc_flag,
    output logic              sc_wr_en,
    output logic              resv_valid,
    output logic [ADDR_W-1:0] resv_addr
);
    op_kind_e ld_kind, st_kind;
    logic     st_hit;
    logic     do_set, do_clr;

    mon_opclass #(.STORE_LANE(1'b0)) u_ld_cls (
        .req(ld_req), .opc(ld_opc), .kind(ld_kind)
    );

    mon_opclass #(.STORE_LANE(1'b1)) u_st_cls (
        .req(st_req), .opc(st_opc), .kind(st_kind)
    );

    mon_word_match #(.ADDR_W(ADDR_W), .IGN_LSB(IGN_LSB)) u_match (
        .a(st_addr), .b(resv_addr), .hit(st_hit)
    );

    // Outcome of a conditional store and the kill/set controls.
    always_comb begin
        sc_flag  = (st_kind == OPK_COND_ST) && resv_valid && st_hit;
        sc_wr_en = sc_flag;
        do_set   = (ld_kind == OPK_LOADRES);
        do_clr   = (st_kind == OPK_COND_ST) ||
                   ((st_kind == OPK_PLAIN_ST) && st_hit);
    end

    mon_resv_state #(.ADDR_W(ADDR_W)) u_state (
        .clk(clk), .rst_n(rst_n),
        .set_en(do_set), .set_addr(ld_addr), .clr_en(do_clr),
        .valid(resv_valid), .addr(resv_addr)
    );
endmodule

// File: rtl/llsc_monitor_chk.sv
// Property checker for the reservation monitor, bound to every instance.
// Decodes requests from the ports on its own.
module llsc_monitor_chk #(
    parameter int ADDR_W  = 32,
    parameter int IGN_LSB = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_req,
    input logic [5:0]        ld_opc,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              st_req,
    input logic [5:0]        st_opc,
    input logic [ADDR_W-1:0] st_addr,
    input logic              sc_flag,
    input logic              sc_wr_en,
    input logic              resv_valid,
    input logic [ADDR_W-1:0] resv_addr
);
    logic c_lr, c_sc, c_pst, c_same;

    // Independent request decode from port values.
    always_comb begin
        c_lr   = ld_req && ld_opc == 6'h1B;
        c_sc   = st_req && st_opc == 6'h33;
        c_pst  = st_req && st_opc[5:2] == 4'hD;
        c_same = st_addr[ADDR_W-1:IGN_LSB] == resv_addr[ADDR_W-1:IGN_LSB];
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!resv_valid && resv_addr == '0)); // R1
    AST_LR_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        c_lr |=> (resv_valid && resv_addr == $past(ld_addr))); // R2
    AST_PASS_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        sc_flag |-> (c_sc && resv_valid && c_same)); // R3
    AST_WE_ONLY_ON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        sc_wr_en |-> sc_flag); // R4
    AST_SC_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sc && !c_lr) |=> !resv_valid); // R5
    AST_STORE_HIT_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_pst && c_same && !c_lr) |=> !resv_valid); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_lr && !c_sc && !(c_pst && c_same))
        |=> ($stable(resv_valid) && $stable(resv_addr))); // R9
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W), .IGN_LSB(IGN_LSB)) u_chk (.*);

// File: tb/llsc_monitor_test.sv
`timescale 1ns/1ps
module llsc_monitor_test;
    typedef struct packed {
        logic        ldv;
        logic [5:0]  ldo;
        logic [31:0] lda;
        logic        stv;
        logic [5:0]  sto;
        logic [31:0] sta;
        logic        eflag;
        logic        evalid;
        logic [31:0] eaddr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b1,6'h1B,32'h1000, 1'b0,6'h00,32'h0,    1'b0,1'b1,32'h1000,4'd2}, // R2
        '{1'b0,6'h00,32'h0,    1'b1,6'h33,32'h1000, 1'b1,1'b0,32'h1000,4'd3}, // R3 pass
        '{1'b0,6'h00,32'h0,    1'b1,6'h33,32'h1000, 1'b0,1'b0,32'h1000,4'd5}, // R5 fails after kill
        '{1'b1,6'h1B,32'h2000, 1'b0,6'h00,32'h0,    1'b0,1'b1,32'h2000,4'd2}, // R2
        '{1'b0,6'h00,32'h0,    1'b1,6'h33,32'h2004, 1'b0,1'b0,32'h2000,4'd5}, // R5 mismatch still kills
        '{1'b1,6'h1B,32'h3000, 1'b0,6'h00,32'h0,    1'b0,1'b1,32'h3000,4'd2}, // R2
        '{1'b0,6'h00,32'h0,    1'b1,6'h35,32'h3100, 1'b0,1'b1,32'h3000,4'd6}, // R6 miss
        '{1'b0,6'h00,32'h0,    1'b1,6'h36,32'h3003, 1'b0,1'b0,32'h3000,4'd7}, // R7 byte hit
        '{1'b1,6'h1B,32'h4002, 1'b0,6'h00,32'h0,    1'b0,1'b1,32'h4002,4'd2}, // R2
        '{1'b0,6'h00,32'h0,    1'b1,6'h33,32'h4000, 1'b1,1'b0,32'h4002,4'd7}, // R7 low bits ignored
        '{1'b1,6'h1B,32'h5000, 1'b1,6'h37,32'h5000, 1'b0,1'b1,32'h5000,4'd8}, // R8 vs plain store
        '{1'b1,6'h1B,32'h6000, 1'b1,6'h33,32'h5000, 1'b1,1'b1,32'h6000,4'd8}, // R8 vs cond store
        '{1'b1,6'h33,32'h7000, 1'b1,6'h1B,32'h6000, 1'b0,1'b1,32'h6000,4'd9}, // R9 wrong lanes
        '{1'b0,6'h00,32'h0,    1'b0,6'h33,32'h6000, 1'b0,1'b1,32'h6000,4'd9}, // R9 st_req low
        '{1'b0,6'h1B,32'h8000, 1'b0,6'h00,32'h0,    1'b0,1'b1,32'h6000,4'd9}, // R9 ld_req low
        '{1'b0,6'h00,32'h0,    1'b1,6'h34,32'h6001, 1'b0,1'b0,32'h6000,4'd6}, // R6 hit
        '{1'b1,6'h1B,32'hA000, 1'b1,6'h11,32'hA000, 1'b0,1'b1,32'hA000,4'd9}, // R9 unknown opcode
        '{1'b0,6'h00,32'h0,    1'b1,6'h35,32'hA004, 1'b0,1'b1,32'hA000,4'd6}  // R6 neighbour word
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_req = 1'b0, st_req = 1'b0;
    logic [5:0]  ld_opc = '0, st_opc = '0;
    logic [31:0] ld_addr = '0, st_addr = '0;
    logic        sc_flag, sc_wr_en, resv_valid;
    logic [31:0] resv_addr;
    logic [31:0] mem [16];
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    llsc_monitor uut (
        .clk(clk), .rst_n(rst_n),
        .ld_req(ld_req), .ld_opc(ld_opc), .ld_addr(ld_addr),
        .st_req(st_req), .st_opc(st_opc), .st_addr(st_addr),
        .sc_flag(sc_flag), .sc_wr_en(sc_wr_en),
        .resv_valid(resv_valid), .resv_addr(resv_addr)
    );

    // Bench memory: conditional store writes its address as data.
    initial for (int i = 0; i < 16; i++) mem[i] = '0;
    always @(posedge clk) if (sc_wr_en) mem[st_addr[5:2]] <= st_addr;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ld_req = 0; ld_opc = 0; ld_addr = 0;
        st_req = 0; st_opc = 0; st_addr = 0;
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid after reset", {31'b0, resv_valid}, 0);
        check("R1 addr after reset", resv_addr, 0);
        check("R4 no write at idle", {31'b0, sc_wr_en}, 0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            ld_req = TBL[k].ldv; ld_opc = TBL[k].ldo; ld_addr = TBL[k].lda;
            st_req = TBL[k].stv; st_opc = TBL[k].sto; st_addr = TBL[k].sta;
            #1;
            check($sformatf("R%0d flag vec %0d", TBL[k].req, k), {31'b0, sc_flag}, {31'b0, TBL[k].eflag});
            check($sformatf("R4 wr_en vec %0d", k), {31'b0, sc_wr_en}, {31'b0, TBL[k].eflag});
            @(posedge clk); #1;
            idle();
            check($sformatf("R%0d valid vec %0d", TBL[k].req, k), {31'b0, resv_valid}, {31'b0, TBL[k].evalid});
            check($sformatf("R%0d addr vec %0d", TBL[k].req, k), resv_addr, TBL[k].eaddr);
        end

        // R4: only passing conditional stores reached memory.
        check("R4 mem word 0", mem[0], 32'h5000);
        check("R4 mem word 1 untouched", mem[1], 32'h0);

        // R1: reset in the middle of a live reservation.
        @(negedge clk);
        ld_req = 1; ld_opc = 6'h1B; ld_addr = 32'h9000;
        @(negedge clk);
        idle();
        check("R2 live before reset", {31'b0, resv_valid}, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 valid cleared", {31'b0, resv_valid}, 0);
        check("R1 addr cleared", resv_addr, 0);
        rst_n = 1'b1;

        // R3: conditional store after reset fails even at address 0.
        @(negedge clk);
        st_req = 1; st_opc = 6'h33; st_addr = 32'h0;
        #1;
        check("R3 no reservation after reset", {31'b0, sc_flag}, 0);
        @(negedge clk);
        idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule